// File: doc/BRIEF.md
# Edge-Interval Parity Entropy Extractor

This block turns an asynchronous digital noise waveform into unbiased random bytes. The noise pin is brought into the clock domain and sampled at a fixed tick rate. The block times the gap between consecutive transitions of the sampled signal. The lowest bit of each tick count becomes one raw bit. Only every other gap is timed, and the gap that follows a timed one is left alone. An optional mode times a run of three consecutive gaps as one raw bit instead of a single gap.

Raw bits pass through a pairwise von Neumann debiaser. Bits that survive are packed into bytes, most significant bit first, and each byte is offered on a valid/ready handshake. If the noise source goes flat or degrades to a single parity, the output stops instead of turning deterministic. A probe pin pulses at the start and at the end of every timed gap, so the sampling can be watched on an oscilloscope.

Top module: `edge_parity_rng`

## Requirements
- R1: `noise_in` passes through a two-stage synchronizer and is sampled once every `DIV` clock cycles. A rising or a falling change between two samples is a boundary.
- R2: In single mode a raw bit is bit 0 of N, where N is the number of ticks from the starting boundary to the ending boundary. A boundary that falls exactly N ticks after the previous one gives a count of N.
- R3: Timed gaps alternate with untimed ones. The boundary that ends a timed gap opens an untimed gap, and the next boundary starts the next timed gap.
- R4: Raw bits are grouped in non-overlapping pairs. A pair of equal bits yields nothing. A pair of unequal bits yields its first bit.
- R5: When the noise stops changing, or when every raw bit has the same value, no byte is produced.
- R6: When `triple_mode` is 1, N is the total tick count over three consecutive gaps, which gives one raw bit. The untimed gap that follows is a single gap.
- R7: `marker` is high for exactly one cycle when a timed gap starts and for exactly one cycle when it ends.
- R8: A timed span with N >= 2^CNT_W gives no raw bit. Its end marker is still pulsed.
- R9: Bits fill a byte MSB first. A full byte appears on `out_data` with `out_valid` = 1 and stays unchanged until a cycle in which `out_ready` is 1.
- R10: A debiased bit that arrives while `out_valid` is 1 is discarded. This includes the cycle in which `out_ready` accepts the byte. The next byte is built only from bits that arrive later.
- R11: While `rst_n` is 0, `out_valid` and `marker` are 0. Reset clears the pending pair bit, the partly filled byte, the counter and the alternation state.
- R12: The mode is taken from `triple_mode` at the boundary that starts a timed span. A change during the span does not affect that span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| noise_in | input | 1 | Asynchronous digital noise waveform |
| triple_mode | input | 1 | 1: time three gaps per raw bit; 0: one gap |
| out_data | output | BYTE_W | Random byte, MSB is the earliest bit |
| out_valid | output | 1 | Byte on `out_data` is available |
| out_ready | input | 1 | Consumer takes the byte in this cycle |
| marker | output | 1 | One-cycle pulse at the start and at the end of each timed span |

## Verification
Two things can land in the same cycle: a new debiased bit reaching the packer, and the consumer accepting the waiting byte. The bench holds `out_ready` low until a byte is waiting and more bits have been dropped. It then sets up a pending pair bit and ends a timed gap whose parity differs from it. It watches `marker` for the end pulse and raises `out_ready` in the following cycle, which is exactly the cycle the debiased bit reaches the packer. That bit must be lost, so the bench judges the case by checking that the next bytes delivered match a bit stream with the bit removed, and that no partial byte shows up.

// File: rtl/eip_pkg.sv
package eip_pkg;

  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_MEAS = 1'b1
  } meas_st_e;

  localparam int unsigned TRIPLE_SEGS = 3;

endpackage

// File: rtl/eip_sampler.sv
module eip_sampler #(
  parameter int unsigned DIV    = 3,
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic noise_async,
  output logic tick_o,
  output logic edge_o
);

  localparam int unsigned    DW       = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0]  DIV_LAST = DW'(DIV - 1);

  logic [SYNC_N-1:0] sync_q, sync_d;
  logic [DW-1:0]     div_q, div_d;
  logic              hold_q, hold_d;
  logic              tick_q, tick_d;
  logic              edge_q, edge_d;
  logic              tick_now;
  logic              smp;

  assign smp = sync_q[SYNC_N-1];

  always_comb begin
    sync_d   = {sync_q[SYNC_N-2:0], noise_async};
    tick_now = (div_q == DIV_LAST);
    div_d    = tick_now ? '0 : div_q + 1'b1;
    hold_d   = tick_now ? smp : hold_q;
    tick_d   = tick_now;
    edge_d   = tick_now && (smp != hold_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      div_q  <= '0;
      hold_q <= 1'b0;
      tick_q <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      div_q  <= div_d;
      hold_q <= hold_d;
      tick_q <= tick_d;
      edge_q <= edge_d;
    end
  end

  assign tick_o = tick_q;
  assign edge_o = edge_q;

  // R1: ticks are never back to back when DIV >= 2
  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);

  // R1: a boundary is reported only when the held sample has flipped
  a_r1_edge_flips_sample: assert property (@(posedge clk) disable iff (!rst_n)
    edge_q |-> (hold_q != $past(hold_q)));

endmodule

// File: rtl/eip_interval.sv
module eip_interval
  import eip_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic edge_i,
  input  logic triple_i,
  output logic raw_vld_o,
  output logic raw_bit_o,
  output logic marker_o
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [1:0]       SEG_LAST = 2'(TRIPLE_SEGS - 1);

  meas_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       seg_q, seg_d;
  logic             trip_q, trip_d;
  logic             raw_vld_q, raw_vld_d;
  logic             raw_bit_q, raw_bit_d;
  logic             mark_q, mark_d;
  logic             cnt_sat;
  logic [CNT_W-1:0] cnt_inc;
  logic             final_seg;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    seg_d     = seg_q;
    trip_d    = trip_q;
    raw_vld_d = 1'b0;
    raw_bit_d = raw_bit_q;
    mark_d    = 1'b0;
    cnt_sat   = (cnt_q == CNT_MAX);
    cnt_inc   = cnt_sat ? cnt_q : cnt_q + 1'b1;
    final_seg = !trip_q || (seg_q == SEG_LAST);
    unique case (st_q)
      ST_WAIT: begin
        if (edge_i) begin
          st_d   = ST_MEAS;
          cnt_d  = '0;
          seg_d  = '0;
          trip_d = triple_i;
          mark_d = 1'b1;
        end
      end
      ST_MEAS: begin
        if (tick_i) begin
          if (edge_i && final_seg) begin
            st_d      = ST_WAIT;
            mark_d    = 1'b1;
            raw_vld_d = !cnt_sat;
            raw_bit_d = ~cnt_q[0];
          end else begin
            cnt_d = cnt_inc;
            if (edge_i) seg_d = seg_q + 1'b1;
          end
        end
      end
      default: st_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_WAIT;
      cnt_q     <= '0;
      seg_q     <= '0;
      trip_q    <= 1'b0;
      raw_vld_q <= 1'b0;
      raw_bit_q <= 1'b0;
      mark_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      seg_q     <= seg_d;
      trip_q    <= trip_d;
      raw_vld_q <= raw_vld_d;
      raw_bit_q <= raw_bit_d;
      mark_q    <= mark_d;
    end
  end

  assign raw_vld_o = raw_vld_q;
  assign raw_bit_o = raw_bit_q;
  assign marker_o  = mark_q;

  // R7: the probe pulse lasts a single cycle
  a_r7_marker_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mark_q |=> !mark_q);

  // R8: no raw bit leaves a span whose count had saturated
  a_r8_no_bit_when_saturated: assert property (@(posedge clk) disable iff (!rst_n)
    raw_vld_q |-> ($past(cnt_q) != CNT_MAX));

  // R3: after a raw bit the next gap is not timed
  a_r3_skip_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
    raw_vld_q |-> (st_q == ST_WAIT));

endmodule

// File: rtl/eip_vonneumann.sv
module eip_vonneumann (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_vld_i,
  input  logic raw_bit_i,
  output logic bit_vld_o,
  output logic bit_o
);

  logic have_q, have_d;
  logic first_q, first_d;
  logic vld_q, vld_d;
  logic bit_q, bit_d;

  always_comb begin
    have_d  = have_q;
    first_d = first_q;
    vld_d   = 1'b0;
    bit_d   = bit_q;
    if (raw_vld_i) begin
      if (!have_q) begin
        have_d  = 1'b1;
        first_d = raw_bit_i;
      end else begin
        have_d = 1'b0;
        if (first_q != raw_bit_i) begin
          vld_d = 1'b1;
          bit_d = first_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q  <= 1'b0;
      first_q <= 1'b0;
      vld_q   <= 1'b0;
      bit_q   <= 1'b0;
    end else begin
      have_q  <= have_d;
      first_q <= first_d;
      vld_q   <= vld_d;
      bit_q   <= bit_d;
    end
  end

  assign bit_vld_o = vld_q;
  assign bit_o     = bit_q;

  // R4: an output bit closes a pair of unequal raw bits and repeats the first
  a_r4_unequal_pair: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> ($past(have_q) && $past(raw_vld_i) &&
               ($past(raw_bit_i) != $past(first_q)) && (bit_q == $past(first_q))));

endmodule

// File: rtl/eip_packer.sv
module eip_packer #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o,
  input  logic              ready_i
);

  localparam int unsigned   BW       = $clog2(BYTE_W);
  localparam logic [BW-1:0] BIT_LAST = BW'(BYTE_W - 1);

  logic [BYTE_W-1:0] sr_q, sr_d;
  logic [BW-1:0]     cnt_q, cnt_d;
  logic              full_q, full_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic [BYTE_W-1:0] shifted;
  logic              accept;

  always_comb begin
    sr_d    = sr_q;
    cnt_d   = cnt_q;
    full_d  = full_q;
    data_d  = data_q;
    accept  = bit_vld_i && !full_q;
    shifted = {sr_q[BYTE_W-2:0], bit_i};
    if (full_q && ready_i) full_d = 1'b0;
    if (accept) begin
      sr_d = shifted;
      if (cnt_q == BIT_LAST) begin
        data_d = shifted;
        full_d = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      full_q <= full_d;
      data_q <= data_d;
    end
  end

  assign data_o  = data_q;
  assign valid_o = full_q;

  // R9: a waiting byte is held unchanged until it is taken
  a_r9_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !ready_i) |=> (full_q && $stable(data_q)));

  // R10: a bit arriving while a byte waits leaves the fill state untouched
  a_r10_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld_i && full_q) |=> ($stable(cnt_q) && $stable(sr_q)));

endmodule

// File: rtl/edge_parity_rng.sv
module edge_parity_rng #(
  parameter int unsigned DIV    = 3,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              noise_in,
  input  logic              triple_mode,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              marker
);

  logic [1:0] rst_sync_q;
  logic       rst_n_i;
  logic       tick, edge_evt;
  logic       raw_vld, raw_bit;
  logic       db_vld, db_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  eip_sampler #(.DIV(DIV), .SYNC_N(2)) u_sampler (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .noise_async (noise_in),
    .tick_o      (tick),
    .edge_o      (edge_evt)
  );

  eip_interval #(.CNT_W(CNT_W)) u_interval (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .tick_i    (tick),
    .edge_i    (edge_evt),
    .triple_i  (triple_mode),
    .raw_vld_o (raw_vld),
    .raw_bit_o (raw_bit),
    .marker_o  (marker)
  );

  eip_vonneumann u_debias (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .raw_vld_i (raw_vld),
    .raw_bit_i (raw_bit),
    .bit_vld_o (db_vld),
    .bit_o     (db_bit)
  );

  eip_packer #(.BYTE_W(BYTE_W)) u_packer (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .bit_vld_i (db_vld),
    .bit_i     (db_bit),
    .data_o    (out_data),
    .valid_o   (out_valid),
    .ready_i   (out_ready)
  );

  // R11: no output activity while reset is applied
  a_r11_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && !marker));

endmodule

// File: tb/edge_parity_rng_bench.sv
module edge_parity_rng_bench;

  localparam int DIV   = 3;
  localparam int CNT_W = 6;
  localparam int BW    = 8;
  localparam int SAT   = 1 << CNT_W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          noise;
  logic          mode;
  logic [BW-1:0] out_data;
  logic          out_valid;
  logic          out_ready;
  logic          marker;

  always #2 clk = ~clk;

  edge_parity_rng #(.DIV(DIV), .CNT_W(CNT_W), .BYTE_W(BW)) u_edge_parity_rng (
    .clk         (clk),
    .rst_n       (rst_n),
    .noise_in    (noise),
    .triple_mode (mode),
    .out_data    (out_data),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .marker      (marker)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R11";

  task automatic chk(input bit ok, input string t, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  // reference model state
  bit          m_meas, m_trip, m_have, m_first, m_hold, m_full;
  int          m_sum, m_seg, m_cnt, m_dropped, exp_mk;
  logic [7:0]  m_sr;
  logic [7:0]  exp_q[$];
  int          mk_seen = 0, vld_seen = 0, mk_base = 0;

  always begin
    @(negedge clk);
    #1;
    if (marker) mk_seen++;
    if (out_valid) vld_seen++;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(1'b0, tag, "unexpected byte", int'(out_data), -1);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        chk(out_data == e, tag, "byte value", int'(out_data), int'(e));
      end
    end
  end

  task automatic model_reset();
    m_meas = 0; m_trip = 0; m_have = 0; m_first = 0; m_full = 0; m_hold = 0;
    m_sum = 0; m_seg = 0; m_cnt = 0; m_sr = '0; exp_mk = 0; m_dropped = 0;
    exp_q.delete();
    mk_base = mk_seen;
  endtask

  task automatic model_pack(input bit b);
    if (m_full) m_dropped++;
    else begin
      m_sr = {m_sr[6:0], b};
      m_cnt++;
      if (m_cnt == 8) begin
        exp_q.push_back(m_sr);
        m_cnt = 0;
        if (m_hold) m_full = 1;
      end
    end
  endtask

  task automatic model_raw(input bit b);
    if (!m_have) begin m_have = 1; m_first = b; end
    else begin
      m_have = 0;
      if (m_first != b) model_pack(m_first);
    end
  endtask

  task automatic model_edge(input int k);
    if (!m_meas) begin
      m_meas = 1; m_sum = 0; m_seg = 0; m_trip = mode; exp_mk++;
    end else begin
      m_sum += k;
      if (!m_trip || m_seg == 2) begin
        m_meas = 0; exp_mk++;
        if (m_sum < SAT) model_raw(m_sum[0]);
      end else m_seg++;
    end
  endtask

  task automatic edge_after(input int k);
    repeat (k * DIV) @(negedge clk);
    noise = ~noise;
    model_edge(k);
  endtask

  task automatic align();
    while (m_meas) edge_after(3);
  endtask

  task automatic feed_raw(input bit b);
    align();
    edge_after(2);
    if (m_trip) begin
      edge_after(1); edge_after(1); edge_after(b ? 1 : 2);
    end else edge_after(b ? 1 : 2);
  endtask

  task automatic pad();
    bit t = 0;
    while (m_cnt != 0 || m_have) begin
      if (m_have) feed_raw(t);
      else begin feed_raw(t); feed_raw(!t); end
      t = !t;
    end
  endtask

  task automatic drain();
    repeat (DIV * 12) @(negedge clk);
  endtask

  task automatic end_phase(input string t);
    drain();
    chk(exp_q.size() == 0, t, "bytes still owed", exp_q.size(), 0);
    chk((mk_seen - mk_base) == exp_mk, t, "marker pulses", mk_seen - mk_base, exp_mk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v0;
    logic [7:0] held;
    rst_n = 1'b0; noise = 1'b0; mode = 1'b0; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    // R11: reset state
    chk(out_valid == 1'b0, "R11", "out_valid in reset", out_valid, 0);
    chk(marker == 1'b0, "R11", "marker in reset", marker, 0);
    rst_n = 1'b1;
    model_reset();
    repeat (DIV * 4) @(negedge clk);

    // R1 R2 R3 R4 R7 R9: single-gap sweep over pairs of lengths
    tag = "R1 R2 R3 R4 R7 R9";
    for (int k1 = 1; k1 <= 12; k1++)
      for (int k2 = 1; k2 <= 12; k2++) begin
        edge_after(k1); edge_after(1 + (k1 + k2) % 4);
        edge_after(k2); edge_after(2);
      end
    pad();
    end_phase(tag);

    // R12: mode change in mid span is ignored
    tag = "R12";
    align();
    mode = 1'b0;
    edge_after(2);
    repeat (4 * DIV) @(negedge clk);
    mode = 1'b1;
    repeat (3 * DIV) @(negedge clk);
    noise = ~noise;
    model_edge(7);
    chk(m_meas == 0, "R12", "model span closed by one gap", m_meas, 0);
    pad();
    end_phase(tag);

    // R6: triple mode sweep
    tag = "R6";
    align();
    mode = 1'b1;
    for (int a = 1; a <= 5; a++)
      for (int b = 1; b <= 5; b++)
        for (int c = 1; c <= 5; c++) begin
          edge_after(a); edge_after(b); edge_after(c); edge_after(2);
        end
    pad();
    end_phase(tag);

    // R8: saturating spans are discarded
    tag = "R8";
    align();
    mode = 1'b0;
    for (int i = 0; i < 16; i++) begin
      edge_after(2);
      case (i % 4)
        0: edge_after(SAT);
        1: edge_after(SAT - 1);
        2: edge_after(SAT + 1 + i);
        default: edge_after(5 + i);
      endcase
    end
    pad();
    end_phase(tag);

    // R5: stuck input and constant parity
    tag = "R5";
    v0 = vld_seen;
    repeat (3000) @(negedge clk);
    chk(vld_seen == v0, "R5", "bytes from stuck input", vld_seen - v0, 0);
    chk((mk_seen - mk_base) == exp_mk, "R5", "markers from stuck input", mk_seen - mk_base, exp_mk);
    align();
    for (int i = 0; i < 60; i++) begin
      edge_after(1 + i % 5);
      edge_after(2 * (1 + i % 8));
    end
    drain();
    chk(vld_seen == v0, "R5", "bytes from constant parity", vld_seen - v0, 0);
    end_phase(tag);

    // R9 R10: hold, drop, and bit arriving on the accept cycle
    tag = "R10";
    pad();
    align();
    out_ready = 1'b0; m_hold = 1; m_dropped = 0;
    for (int i = 0; m_dropped < 10; i++) begin
      feed_raw(i % 3 == 0);
      feed_raw(i % 3 != 0);
    end
    drain();
    chk(out_valid == 1'b1, "R9", "valid while waiting", out_valid, 1);
    chk(exp_q.size() == 1, "R10", "model holds one byte", exp_q.size(), 1);
    held = out_data;
    chk(out_data == exp_q[0], "R9", "waiting byte value", int'(out_data), int'(exp_q[0]));
    repeat (30) @(negedge clk);
    chk(out_valid == 1'b1 && out_data == held, "R9", "byte held stable", int'(out_data), int'(held));
    feed_raw(1'b1);
    begin
      int c = 0;
      edge_after(2);
      repeat (DIV * (m_first ? 4 : 3)) @(negedge clk);
      noise = ~noise;
      model_edge(m_first ? 4 : 3);
      do begin @(negedge clk); c++; end while (!marker && c < 50);
      chk(c < 50, "R10", "end marker seen", c, 0);
      @(negedge clk);
      out_ready = 1'b1;
      m_full = 0; m_hold = 0;
    end
    drain();
    chk(exp_q.size() == 0, "R10", "waiting byte taken", exp_q.size(), 0);
    chk(out_valid == 1'b0, "R10", "no partial byte after drops", out_valid, 0);
    for (int i = 0; i < 40; i++) feed_raw((i % 5) < 2);
    pad();
    end_phase(tag);

    // R11: reset in mid stream clears partial state
    tag = "R11";
    feed_raw(1'b1); feed_raw(1'b0); feed_raw(1'b0); feed_raw(1'b1);
    noise = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R11", "out_valid during reset", out_valid, 0);
    chk(marker == 1'b0, "R11", "marker during reset", marker, 0);
    rst_n = 1'b1;
    model_reset();
    mode = 1'b0;
    repeat (DIV * 4) @(negedge clk);
    for (int i = 0; i < 48; i++) feed_raw(((i * 7) % 3) == 1);
    pad();
    end_phase(tag);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule